// File: doc/BRIEF.md
# Memory Dependence Wakeup Scoreboard

This block keeps track of the memory operations of one thread of an out-of-order core while they wait to issue. Each operation takes one slot of a fixed table and carries its sequence number. When it is inserted, the block works out which older stores or barriers it has to wait for. It then holds a count of producers that have not finished and a flag saying whether its source registers are ready. When the count is zero and the flag is set, the slot is offered on a ready output, oldest sequence number first.

Finishing a store, an atomic or a barrier wakes every slot that was waiting on it. A squash frees every slot younger than a boundary sequence number. An issued slot can be sent back for rescheduling, and a later replay command returns it to the ready output. The store-set predictor, address disambiguation and the issue queue are outside this block. A predicted producer arrives as a sequence number on the insert port.

Every slot runs its own state machine with five states:
- FREE: the slot is empty.
- WAIT: producers are still pending, or the registers are not ready.
- READY: the slot is offered on the output.
- ISSUED: the handshake has accepted the slot.
- REPLAY: the slot sits on the rescheduled list.

The transitions are:
- alloc: FREE goes to WAIT, or straight to READY when nothing blocks the new slot.
- wake: WAIT goes to READY.
- issue: READY goes to ISSUED.
- finish: ISSUED goes to FREE.
- resched: ISSUED goes to REPLAY.
- replay: REPLAY goes to READY.
- kill: any occupied state goes to FREE when a squash covers the slot.

Top module: `mdw_scoreboard`

## Requirements
- R1: After reset every slot is free, `out_valid` and `tbl_full` are low and all four counters read zero.
- R2: An insert goes into the lowest-numbered free slot, which `ins_slot` shows in advance. While `tbl_full` is high (no free slot), an insert is refused and leaves the table and the counters unchanged.
- R3: `ins_kind` encodes 0=load, 1=store, 2=atomic, 3=barrier. A barrier with `ins_rd_bar` set is a load barrier, one with `ins_wr_bar` set is a store barrier, and one with both set (a transactional command or a full fence) is both. While any load barrier is outstanding, a new load depends on every outstanding load barrier. While any store barrier is outstanding, a new store or atomic depends on every outstanding store barrier. In either case the predicted producer is not used.
- R4: With no relevant barrier outstanding, a load, store or atomic that has `pred_valid` set depends on the occupied store or atomic slot whose sequence number equals `pred_seq`. If no such slot exists, it has no producer. A barrier never has producers.
- R5: A new entry with no producers and `ins_regs_rdy` set is offered on `out_valid` in the next cycle.
- R6: A register-ready notice for a waiting slot sets its flag. If its producer count is already zero, the slot is offered in the next cycle.
- R7: Finishing an issued store, atomic or barrier takes one off the count of each slot that depends on it. A dependent is offered only once its count reaches zero and its registers are ready.
- R8: Finishing an issued load frees its slot and wakes nothing. A finish request for a slot that is not issued is ignored.
- R9: Once a barrier finishes, it no longer holds back later loads or stores.
- R10: A squash with boundary N frees every occupied slot whose sequence number is greater than N, including rescheduled ones. In the squash cycle `out_valid` is low and every other command is ignored.
- R11: A reschedule request moves an issued slot off the output. A replay command offers every rescheduled slot again.
- R12: Of the offered slots, the one with the smallest sequence number is shown. It stays shown until `out_ready` is high, and an accepted slot becomes issued.
- R13: `cnt_ld_ins` counts accepted loads and `cnt_st_ins` counts accepted stores and atomics. `cnt_ld_conf` and `cnt_st_conf` count those among them that were inserted with at least one producer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid | input | 1 | Insert request |
| ins_kind | input | 2 | Operation kind: 0 load, 1 store, 2 atomic, 3 barrier |
| ins_rd_bar | input | 1 | Barrier orders loads |
| ins_wr_bar | input | 1 | Barrier orders stores |
| ins_seq | input | SEQ_W | Sequence number of the new entry |
| ins_regs_rdy | input | 1 | Source registers already ready |
| pred_valid | input | 1 | A producer store is predicted |
| pred_seq | input | SEQ_W | Sequence number of the predicted store |
| ins_slot | output | SLOT_W | Slot the next insert will take |
| tbl_full | output | 1 | No free slot |
| regrdy_valid | input | 1 | Register-ready notice |
| regrdy_slot | input | SLOT_W | Slot of the notice |
| done_valid | input | 1 | Finish notice |
| done_slot | input | SLOT_W | Slot that finished |
| resched_valid | input | 1 | Reschedule request |
| resched_slot | input | SLOT_W | Slot to reschedule |
| replay_go | input | 1 | Release all rescheduled slots |
| squash_valid | input | 1 | Squash request |
| squash_seq | input | SEQ_W | Squash boundary; younger entries die |
| out_valid | output | 1 | A slot is offered |
| out_ready | input | 1 | Consumer takes the offered slot |
| out_slot | output | SLOT_W | Offered slot |
| out_seq | output | SEQ_W | Sequence number of the offered slot |
| cnt_ld_ins | output | CNT_W | Loads inserted |
| cnt_st_ins | output | CNT_W | Stores and atomics inserted |
| cnt_ld_conf | output | CNT_W | Loads inserted with producers |
| cnt_st_conf | output | CNT_W | Stores and atomics inserted with producers |

## Verification
The hardest cases to reach involve commands that land in the same cycle. One is a producer finishing in the same cycle that a new dependent names it. Another is a dependent losing its last producer in the cycle its registers become ready. A third is a squash that catches a slot on the rescheduled list. Directed phases build each of these by hand. A long random phase then draws inserts, finishes, reschedules, replays and squashes together, aiming predicted sequence numbers at recent stores. A behavioural model with per-slot dependent queues is compared with the outputs on every cycle.

// File: rtl/mdw_pkg.sv
package mdw_pkg;

    typedef enum logic [1:0] {
        K_LOAD    = 2'd0,
        K_STORE   = 2'd1,
        K_ATOMIC  = 2'd2,
        K_BARRIER = 2'd3
    } mdw_kind_e;

    typedef enum logic [2:0] {
        ST_FREE   = 3'd0,
        ST_WAIT   = 3'd1,
        ST_RDY    = 3'd2,
        ST_ISSUED = 3'd3,
        ST_REPLAY = 3'd4
    } mdw_state_e;

endpackage

// File: rtl/mdw_pick_low.sv
module mdw_pick_low #(
    parameter int N = 16,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic [IW-1:0] idx,
    output logic          any
);
    always_comb begin
        idx = '0;
        any = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = IW'(i);
                any = 1'b1;
            end
        end
    end
endmodule

// File: rtl/mdw_oldest.sv
module mdw_oldest #(
    parameter int N     = 16,
    parameter int SEQ_W = 16,
    localparam int IW   = $clog2(N)
) (
    input  logic [N-1:0]     req,
    input  logic [SEQ_W-1:0] seqs [N],
    output logic [IW-1:0]    idx,
    output logic             any
);
    logic [SEQ_W-1:0] best;

    always_comb begin
        idx  = '0;
        any  = 1'b0;
        best = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && (!any || seqs[i] < best)) begin
                idx  = IW'(i);
                best = seqs[i];
                any  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/mdw_entry.sv
module mdw_entry
    import mdw_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int SEQ_W  = 16,
    localparam int DCNT_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              squash_valid,
    input  logic [SEQ_W-1:0]  squash_seq,
    input  logic              ins_here,
    input  logic [DEPTH-1:0]  ins_oh,
    input  logic              ins_is_prod,
    input  mdw_kind_e         ins_kind,
    input  logic [SEQ_W-1:0]  ins_seq,
    input  logic [DCNT_W-1:0] ins_deps,
    input  logic              ins_regs,
    input  logic              regrdy_here,
    input  logic              dec,
    input  logic              issue_here,
    input  logic              done_here,
    input  logic              resched_here,
    input  logic              replay_go,
    output mdw_state_e        state_o,
    output logic [SEQ_W-1:0]  seq_o,
    output mdw_kind_e         kind_o,
    output logic [DEPTH-1:0]  row_o
);
    mdw_state_e        state_q, state_n;
    logic [SEQ_W-1:0]  seq_q, seq_n;
    mdw_kind_e         kind_q, kind_n;
    logic [DCNT_W-1:0] cnt_q, cnt_n;
    logic              regs_q, regs_n;
    logic [DEPTH-1:0]  row_q, row_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FREE;
            seq_q   <= '0;
            kind_q  <= K_LOAD;
            cnt_q   <= '0;
            regs_q  <= 1'b0;
            row_q   <= '0;
        end else begin
            state_q <= state_n;
            seq_q   <= seq_n;
            kind_q  <= kind_n;
            cnt_q   <= cnt_n;
            regs_q  <= regs_n;
            row_q   <= row_n;
        end
    end

    always_comb begin
        state_n = state_q;
        seq_n   = seq_q;
        kind_n  = kind_q;
        cnt_n   = cnt_q;
        regs_n  = regs_q;
        row_n   = row_q;
        if (squash_valid) begin
            if (state_q != ST_FREE && seq_q > squash_seq) begin
                state_n = ST_FREE;
                row_n   = '0;
            end
        end else begin
            // a new slot overwrites its own column in this producer row
            row_n = (row_q & ~ins_oh) | (ins_is_prod ? ins_oh : '0);
            unique case (state_q)
                ST_FREE: begin
                    if (ins_here) begin
                        seq_n   = ins_seq;
                        kind_n  = ins_kind;
                        cnt_n   = ins_deps;
                        regs_n  = ins_regs;
                        state_n = (ins_deps == '0 && ins_regs) ? ST_RDY : ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    cnt_n  = cnt_q - DCNT_W'(dec);
                    regs_n = regs_q | regrdy_here;
                    if (cnt_n == '0 && regs_n) state_n = ST_RDY;
                end
                ST_RDY: begin
                    if (issue_here) state_n = ST_ISSUED;
                end
                ST_ISSUED: begin
                    if (done_here) begin
                        state_n = ST_FREE;
                        row_n   = '0;
                    end else if (resched_here) begin
                        state_n = ST_REPLAY;
                    end
                end
                ST_REPLAY: begin
                    if (replay_go) state_n = ST_RDY;
                end
                default: state_n = ST_FREE;
            endcase
        end
    end

    assign state_o = state_q;
    assign seq_o   = seq_q;
    assign kind_o  = kind_q;
    assign row_o   = row_q;
endmodule

// File: rtl/mdw_scoreboard.sv
module mdw_scoreboard
    import mdw_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int SEQ_W = 16,
    parameter int CNT_W = 32,
    localparam int SLOT_W = $clog2(DEPTH),
    localparam int DCNT_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ins_valid,
    input  logic [1:0]        ins_kind,
    input  logic              ins_rd_bar,
    input  logic              ins_wr_bar,
    input  logic [SEQ_W-1:0]  ins_seq,
    input  logic              ins_regs_rdy,
    input  logic              pred_valid,
    input  logic [SEQ_W-1:0]  pred_seq,
    output logic [SLOT_W-1:0] ins_slot,
    output logic              tbl_full,
    input  logic              regrdy_valid,
    input  logic [SLOT_W-1:0] regrdy_slot,
    input  logic              done_valid,
    input  logic [SLOT_W-1:0] done_slot,
    input  logic              resched_valid,
    input  logic [SLOT_W-1:0] resched_slot,
    input  logic              replay_go,
    input  logic              squash_valid,
    input  logic [SEQ_W-1:0]  squash_seq,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [SLOT_W-1:0] out_slot,
    output logic [SEQ_W-1:0]  out_seq,
    output logic [CNT_W-1:0]  cnt_ld_ins,
    output logic [CNT_W-1:0]  cnt_st_ins,
    output logic [CNT_W-1:0]  cnt_ld_conf,
    output logic [CNT_W-1:0]  cnt_st_conf
);
    mdw_state_e        st  [DEPTH];
    logic [SEQ_W-1:0]  sq  [DEPTH];
    mdw_kind_e         kd  [DEPTH];
    logic [DEPTH-1:0]  row [DEPTH];

    logic [DEPTH-1:0]  occ_v, rdy_v, free_v;
    logic [DEPTH-1:0]  lbar_q, sbar_q, lbar_live, sbar_live;
    logic [DEPTH-1:0]  pred_v, prod_v, ins_oh, wake_oh, wake_col;
    logic [SLOT_W-1:0] alloc_idx, sel_idx;
    logic              has_free, rdy_any;
    logic              cmd_en, ins_accept, wake_en, issue_fire;
    mdw_kind_e         new_kind;
    logic              new_is_ld, new_is_st;
    logic [DCNT_W-1:0] ins_deps;

    assign new_kind  = mdw_kind_e'(ins_kind);
    assign new_is_ld = (new_kind == K_LOAD);
    assign new_is_st = (new_kind == K_STORE) || (new_kind == K_ATOMIC);

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            occ_v[i]  = (st[i] != ST_FREE);
            free_v[i] = (st[i] == ST_FREE);
            rdy_v[i]  = (st[i] == ST_RDY);
        end
    end

    mdw_pick_low #(.N(DEPTH)) u_alloc (
        .req (free_v),
        .idx (alloc_idx),
        .any (has_free)
    );

    mdw_oldest #(.N(DEPTH), .SEQ_W(SEQ_W)) u_oldest (
        .req  (rdy_v),
        .seqs (sq),
        .idx  (sel_idx),
        .any  (rdy_any)
    );

    // squash owns the cycle: all other commands are dropped
    assign cmd_en     = !squash_valid;
    assign ins_slot   = alloc_idx;
    assign tbl_full   = !has_free;
    assign ins_accept = cmd_en && ins_valid && has_free;
    assign ins_oh     = ins_accept ? (DEPTH'(1) << alloc_idx) : '0;
    assign out_valid  = cmd_en && rdy_any;
    assign out_slot   = sel_idx;
    assign out_seq    = sq[sel_idx];
    assign issue_fire = out_valid && out_ready;

    assign wake_en  = cmd_en && done_valid && (st[done_slot] == ST_ISSUED)
                      && (kd[done_slot] != K_LOAD);
    assign wake_oh  = wake_en ? (DEPTH'(1) << done_slot) : '0;
    assign wake_col = wake_en ? row[done_slot] : '0;

    // barrier membership is only meaningful while the slot is occupied
    assign lbar_live = lbar_q & occ_v & ~wake_oh;
    assign sbar_live = sbar_q & occ_v & ~wake_oh;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            pred_v[i] = pred_valid && occ_v[i] && !wake_oh[i]
                        && (kd[i] == K_STORE || kd[i] == K_ATOMIC)
                        && (sq[i] == pred_seq);
        end
        if (new_is_ld && |lbar_live)      prod_v = lbar_live;
        else if (new_is_st && |sbar_live) prod_v = sbar_live;
        else if (new_is_ld || new_is_st)  prod_v = pred_v;
        else                              prod_v = '0;
        ins_deps = '0;
        for (int i = 0; i < DEPTH; i++) begin
            ins_deps = ins_deps + DCNT_W'(prod_v[i]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lbar_q <= '0;
            sbar_q <= '0;
        end else if (ins_accept) begin
            lbar_q[alloc_idx] <= (new_kind == K_BARRIER) && ins_rd_bar;
            sbar_q[alloc_idx] <= (new_kind == K_BARRIER) && ins_wr_bar;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_ld_ins  <= '0;
            cnt_st_ins  <= '0;
            cnt_ld_conf <= '0;
            cnt_st_conf <= '0;
        end else if (ins_accept) begin
            if (new_is_ld) begin
                cnt_ld_ins <= cnt_ld_ins + 1'b1;
                if (ins_deps != '0) cnt_ld_conf <= cnt_ld_conf + 1'b1;
            end
            if (new_is_st) begin
                cnt_st_ins <= cnt_st_ins + 1'b1;
                if (ins_deps != '0) cnt_st_conf <= cnt_st_conf + 1'b1;
            end
        end
    end

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
        mdw_entry #(.DEPTH(DEPTH), .SEQ_W(SEQ_W)) u_entry (
            .clk          (clk),
            .rst_n        (rst_n),
            .squash_valid (squash_valid),
            .squash_seq   (squash_seq),
            .ins_here     (ins_oh[gi]),
            .ins_oh       (ins_oh),
            .ins_is_prod  (prod_v[gi]),
            .ins_kind     (new_kind),
            .ins_seq      (ins_seq),
            .ins_deps     (ins_deps),
            .ins_regs     (ins_regs_rdy),
            .regrdy_here  (cmd_en && regrdy_valid && regrdy_slot == SLOT_W'(gi)),
            .dec          (wake_col[gi]),
            .issue_here   (issue_fire && sel_idx == SLOT_W'(gi)),
            .done_here    (cmd_en && done_valid && done_slot == SLOT_W'(gi)),
            .resched_here (cmd_en && resched_valid && resched_slot == SLOT_W'(gi)),
            .replay_go    (cmd_en && replay_go),
            .state_o      (st[gi]),
            .seq_o        (sq[gi]),
            .kind_o       (kd[gi]),
            .row_o        (row[gi])
        );
    end
endmodule

// File: rtl/mdw_checker.sv
module mdw_checker #(
    parameter int SEQ_W  = 16,
    parameter int CNT_W  = 32,
    parameter int SLOT_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ins_valid,
    input logic              tbl_full,
    input logic              squash_valid,
    input logic              out_valid,
    input logic              out_ready,
    input logic [SLOT_W-1:0] out_slot,
    input logic [SEQ_W-1:0]  out_seq,
    input logic [CNT_W-1:0]  cnt_ld_ins,
    input logic [CNT_W-1:0]  cnt_st_ins,
    input logic [CNT_W-1:0]  cnt_ld_conf,
    input logic [CNT_W-1:0]  cnt_st_conf
);
    p_full_refuse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_full && ins_valid) |=> ($stable(cnt_ld_ins) && $stable(cnt_st_ins)));

    p_squash_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        squash_valid |-> !out_valid);

    p_taken_leaves_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready) |=>
            !(out_valid && out_slot == $past(out_slot) && out_seq == $past(out_seq)));

    p_ld_conf_bound_r13: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_ld_conf <= cnt_ld_ins);

    p_st_conf_bound_r13: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_st_conf <= cnt_st_ins);

    p_ld_mono_r13: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> cnt_ld_ins >= $past(cnt_ld_ins));
endmodule

bind mdw_scoreboard mdw_checker #(.SEQ_W(SEQ_W), .CNT_W(CNT_W), .SLOT_W(SLOT_W)) u_mdw_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ins_valid    (ins_valid),
    .tbl_full     (tbl_full),
    .squash_valid (squash_valid),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_slot     (out_slot),
    .out_seq      (out_seq),
    .cnt_ld_ins   (cnt_ld_ins),
    .cnt_st_ins   (cnt_st_ins),
    .cnt_ld_conf  (cnt_ld_conf),
    .cnt_st_conf  (cnt_st_conf)
);

// File: tb/mdw_scoreboard_test.sv
`timescale 1ns/1ps
module mdw_scoreboard_test;
    localparam int D = 16;
    localparam int SW = 16;
    localparam int KL = 0, KS = 1, KA = 2, KB = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ins_valid = 0, ins_rd_bar = 0, ins_wr_bar = 0, ins_regs_rdy = 0, pred_valid = 0;
    logic [1:0] ins_kind = 0;
    logic [SW-1:0] ins_seq = 0, pred_seq = 0, squash_seq = 0;
    logic regrdy_valid = 0, done_valid = 0, resched_valid = 0, replay_go = 0, squash_valid = 0;
    logic [3:0] regrdy_slot = 0, done_slot = 0, resched_slot = 0;
    logic out_ready = 0;
    logic [3:0] ins_slot, out_slot;
    logic tbl_full, out_valid;
    logic [SW-1:0] out_seq;
    logic [31:0] cnt_ld_ins, cnt_st_ins, cnt_ld_conf, cnt_st_conf;

    always #2 clk = ~clk;

    mdw_scoreboard uut (
        .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_kind(ins_kind),
        .ins_rd_bar(ins_rd_bar), .ins_wr_bar(ins_wr_bar), .ins_seq(ins_seq),
        .ins_regs_rdy(ins_regs_rdy), .pred_valid(pred_valid), .pred_seq(pred_seq),
        .ins_slot(ins_slot), .tbl_full(tbl_full), .regrdy_valid(regrdy_valid),
        .regrdy_slot(regrdy_slot), .done_valid(done_valid), .done_slot(done_slot),
        .resched_valid(resched_valid), .resched_slot(resched_slot), .replay_go(replay_go),
        .squash_valid(squash_valid), .squash_seq(squash_seq), .out_valid(out_valid),
        .out_ready(out_ready), .out_slot(out_slot), .out_seq(out_seq),
        .cnt_ld_ins(cnt_ld_ins), .cnt_st_ins(cnt_st_ins),
        .cnt_ld_conf(cnt_ld_conf), .cnt_st_conf(cnt_st_conf)
    );

    // ---------------- reference model ----------------
    // slot state: 0 free, 1 waiting, 2 offered, 3 issued, 4 rescheduled
    int m_st[D], m_seq[D], m_kind[D], m_cnt[D], s0[D];
    bit m_regs[D], m_lb[D], m_sb[D];
    int m_deps[D][$];
    int pr[$], keep[$];
    int e_ld, e_st, e_ldc, e_stc;
    int n_chk = 0, n_fail = 0;
    string tag = "R1";
    bit finished = 0;

    function automatic int free_low();
        for (int i = 0; i < D; i++) if (m_st[i] == 0) return i;
        return -1;
    endfunction

    function automatic int oldest();
        int b = -1;
        for (int i = 0; i < D; i++)
            if (m_st[i] == 2 && (b < 0 || m_seq[i] < m_seq[b])) b = i;
        return b;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < D; i++) begin
                m_st[i] = 0; m_deps[i].delete(); m_lb[i] = 0; m_sb[i] = 0;
            end
            e_ld = 0; e_st = 0; e_ldc = 0; e_stc = 0;
        end else if (squash_valid) begin
            for (int i = 0; i < D; i++)
                if (m_st[i] != 0 && m_seq[i] > int'(squash_seq)) begin
                    m_st[i] = 0; m_deps[i].delete();
                end
            for (int p = 0; p < D; p++) begin
                keep = {};
                foreach (m_deps[p][k]) if (m_st[m_deps[p][k]] != 0) keep.push_back(m_deps[p][k]);
                m_deps[p] = keep;
            end
        end else begin
            int e, fl, ds, dslot;
            for (int i = 0; i < D; i++) s0[i] = m_st[i];
            e = out_ready ? oldest() : -1;
            fl = free_low();
            ds = -1;
            dslot = int'(done_slot);
            if (done_valid && s0[dslot] == 3) begin
                if (m_kind[dslot] != KL) begin
                    foreach (m_deps[dslot][k]) m_cnt[m_deps[dslot][k]]--;
                    ds = dslot;
                end
                m_deps[dslot].delete();
                m_st[dslot] = 0;
            end
            if (regrdy_valid && s0[regrdy_slot] == 1) m_regs[regrdy_slot] = 1;
            for (int i = 0; i < D; i++)
                if (s0[i] == 1 && m_cnt[i] == 0 && m_regs[i]) m_st[i] = 2;
            if (e >= 0) m_st[e] = 3;
            if (resched_valid && s0[resched_slot] == 3 && !(done_valid && done_slot == resched_slot))
                m_st[resched_slot] = 4;
            if (replay_go) for (int i = 0; i < D; i++) if (s0[i] == 4) m_st[i] = 2;
            if (ins_valid && fl >= 0) begin
                pr = {};
                for (int j = 0; j < D; j++) begin
                    if (s0[j] != 0 && j != ds && ins_kind == KL && m_lb[j]) pr.push_back(j);
                    if (s0[j] != 0 && j != ds && (ins_kind == KS || ins_kind == KA) && m_sb[j])
                        pr.push_back(j);
                end
                if (pr.size() == 0 && ins_kind != KB && pred_valid)
                    for (int j = 0; j < D; j++)
                        if (s0[j] != 0 && j != ds && (m_kind[j] == KS || m_kind[j] == KA)
                            && m_seq[j] == int'(pred_seq)) pr.push_back(j);
                m_seq[fl] = int'(ins_seq); m_kind[fl] = int'(ins_kind);
                m_cnt[fl] = pr.size(); m_regs[fl] = ins_regs_rdy;
                m_lb[fl] = (ins_kind == KB) && ins_rd_bar;
                m_sb[fl] = (ins_kind == KB) && ins_wr_bar;
                m_deps[fl].delete();
                m_st[fl] = (pr.size() == 0 && ins_regs_rdy) ? 2 : 1;
                foreach (pr[k]) m_deps[pr[k]].push_back(fl);
                if (ins_kind == KL) begin e_ld++; if (pr.size() != 0) e_ldc++; end
                if (ins_kind == KS || ins_kind == KA) begin e_st++; if (pr.size() != 0) e_stc++; end
            end
        end
    end

    task automatic chk(string req, string what, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        #1;
        if (rst_n && !finished) begin
            int o, f;
            o = oldest();
            f = free_low();
            chk(tag, "out_valid", out_valid, (!squash_valid && o >= 0));
            if (!squash_valid && o >= 0) begin
                chk(tag, "out_slot", out_slot, o);
                chk(tag, "out_seq", out_seq, m_seq[o]);
            end
            chk("R2", "tbl_full", tbl_full, f < 0);
            if (f >= 0) chk("R2", "ins_slot", ins_slot, f);
            chk("R13", "cnt_ld_ins", cnt_ld_ins, e_ld);
            chk("R13", "cnt_st_ins", cnt_st_ins, e_st);
            chk("R13", "cnt_ld_conf", cnt_ld_conf, e_ldc);
            chk("R13", "cnt_st_conf", cnt_st_conf, e_stc);
        end
    end

    // ---------------- stimulus ----------------
    task automatic tick(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic clr();
        ins_valid = 0; regrdy_valid = 0; done_valid = 0; resched_valid = 0;
        replay_go = 0; squash_valid = 0; pred_valid = 0; ins_rd_bar = 0; ins_wr_bar = 0;
    endtask

    task automatic ins(input int k, input int s, input bit rr, output int slot,
                       input bit pv = 0, input int ps = 0, input bit rd = 0, input bit wr = 0);
        slot = int'(ins_slot);
        ins_valid = 1; ins_kind = 2'(k); ins_seq = SW'(s); ins_regs_rdy = rr;
        pred_valid = pv; pred_seq = SW'(ps); ins_rd_bar = rd; ins_wr_bar = wr;
        tick(); clr();
    endtask

    task automatic regrdy(int s);  regrdy_valid = 1; regrdy_slot = 4'(s); tick(); clr(); endtask
    task automatic done(int s);    done_valid = 1; done_slot = 4'(s); tick(); clr(); endtask
    task automatic resched(int s); resched_valid = 1; resched_slot = 4'(s); tick(); clr(); endtask
    task automatic replay();       replay_go = 1; tick(); clr(); endtask
    task automatic squash(int n);  squash_valid = 1; squash_seq = SW'(n); tick(); clr(); endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        end
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int a, b, c, s1, s2, s3;
        tick(2);
        rst_n = 1;
        tick();
        tag = "R1";
        chk("R1", "reset out_valid", out_valid, 0);
        chk("R1", "reset full", tbl_full, 0);
        chk("R1", "reset cnt", cnt_ld_ins + cnt_st_ins + cnt_ld_conf + cnt_st_conf, 0);
        tick(2);

        tag = "R5"; out_ready = 1;
        ins(KL, 10, 1, a); tick(2);
        tag = "R8"; done(a); tick(2);

        tag = "R6";
        ins(KS, 20, 0, a); tick(2); regrdy(a); tick(2); done(a); tick();

        tag = "R4"; out_ready = 0;
        ins(KS, 30, 1, s1);
        ins(KL, 31, 1, s2, 1, 30);
        ins(KL, 32, 1, s3, 1, 99);
        out_ready = 1; tick(3);
        tag = "R7"; done(s1); tick(3); done(s2); done(s3); tick();

        tag = "R3";
        ins(KB, 40, 0, a, 0, 0, 1, 0);
        ins(KL, 41, 1, b);
        ins(KS, 42, 1, c);
        tick(2); regrdy(a); tick(2);
        ins(KL, 43, 1, s1);
        tick(2);
        tag = "R9"; done(a); tick(3);
        ins(KL, 44, 1, s2); tick(2);
        tag = "R3";
        ins(KB, 45, 1, a, 0, 0, 1, 1);
        ins(KS, 46, 1, b, 1, 42);
        ins(KA, 47, 1, c);
        ins(KL, 48, 1, s3);
        tick(3); done(a); tick(3);
        tag = "R10"; squash(0); tick();

        tag = "R11";
        ins(KL, 50, 1, a); ins(KL, 51, 1, b); tick(3);
        resched(a); resched(b); tick(2); replay(); tick(3);
        resched(a); tick();
        tag = "R10"; squash(50); replay(); tick(2);
        squash(0);

        tag = "R10"; out_ready = 0;
        for (int i = 0; i < 6; i++) ins(i % 3, 60 + i, i % 2, a);
        tick(); squash(62); tick(2); out_ready = 1; tick(4); squash(0);

        tag = "R2"; out_ready = 0;
        for (int i = 0; i < D; i++) ins(KL, 70 + i, 0, a);
        tick();
        ins(KL, 90, 1, a); ins(KS, 91, 1, a); tick();
        squash(0);

        tag = "R12"; out_ready = 0;
        ins(KL, 100, 1, a); ins(KL, 101, 0, b);
        out_ready = 1; tick(); out_ready = 0;
        done(a);
        ins(KL, 102, 1, c); tick(2);
        regrdy(b); tick(2);
        out_ready = 1; tick(); out_ready = 0; tick(2); out_ready = 1; tick(2);
        squash(0);

        tag = "R7";
        begin
            int seqc = 1000;
            for (int cyc = 0; cyc < 4000; cyc++) begin
                clr();
                if ($urandom_range(0, 99) < 60) begin
                    ins_valid = 1; ins_kind = 2'($urandom_range(0, 3));
                    ins_seq = SW'(seqc); seqc++;
                    ins_regs_rdy = 1'($urandom_range(0, 1));
                    pred_valid = 1'($urandom_range(0, 1));
                    pred_seq = SW'(seqc - $urandom_range(1, 6));
                    ins_rd_bar = 1'($urandom_range(0, 1));
                    ins_wr_bar = 1'($urandom_range(0, 1));
                end
                if ($urandom_range(0, 99) < 40) begin regrdy_valid = 1; regrdy_slot = 4'($urandom_range(0, 15)); end
                if ($urandom_range(0, 99) < 50) begin done_valid = 1; done_slot = 4'($urandom_range(0, 15)); end
                if ($urandom_range(0, 99) < 10) begin resched_valid = 1; resched_slot = 4'($urandom_range(0, 15)); end
                replay_go = ($urandom_range(0, 99) < 10);
                if ($urandom_range(0, 99) < 3) begin
                    squash_valid = 1; squash_seq = SW'(seqc - $urandom_range(0, 8));
                end
                out_ready = ($urandom_range(0, 99) < 70);
                tick();
            end
            clr(); tick(2);
        end

        summary();
        $finish;
    end
endmodule